// File: doc/BRIEF.md
# Exclusive Reservation Monitor

This block sits on the memory side of a shared, already arbitrated 32-bit request bus and makes load-reserved / store-conditional pairs safe when several requesters share one memory. Each requester has a source tag and its own level "hold" line. While that line is high, each access the requester issues is treated as exclusive. An exclusive read that the memory acknowledges opens a reservation. The reservation covers one aligned 32-bit word, records the word and the owner's tag, and lasts while the owner's hold line stays high. The exclusive write that follows is the conditional store. The monitor passes it to memory only if the owner still holds a reservation on that word. Otherwise it answers with a one-cycle bus error and the memory never sees the store.

The monitor gates the memory strobe and produces the acknowledge and error seen by the requester. Address, write flag, byte enables and data go straight from the bus to the memory. A small address window (64 bytes at 0xF0000000 by default) is marked as unable to support exclusive access, and any exclusive access to it is refused. A parameter selects what happens when another source touches the reserved word. In stall mode its access is held off until the reservation ends. In break mode the access proceeds and the reservation is destroyed.

Top module: `excl_resv_monitor`

## Requirements
- R1: While reset is active and after it, bus_ack, bus_err and mem_stb are low and no reservation exists, so a conditional store issued right after reset is refused.
- R2: A request is sampled when bus_cyc and bus_stb are both high. An exclusive read (hold line of bus_src high, bus_we low) outside the refused window is forwarded on mem_stb. A memory acknowledge is returned as a one-cycle bus_ack on the second clock edge after the request is first sampled. The acknowledged read opens a reservation on its word for that source.
- R3: A conditional store (exclusive write) by the owner to the reserved word is forwarded and acknowledged on the second edge. Address bits 1:0 take no part in the word match. The reservation is then gone, so a repeat store is refused.
- R4: A conditional store without a matching reservation gets a one-cycle bus_err on the first edge, in place of bus_ack, with mem_stb never raised. The cases are: no reservation, another word, or another owner. If the source owned a reservation, that reservation is cleared.
- R5: Any exclusive access whose address falls in the aligned 64-byte window at 0xF0000000 is refused with bus_err on the first edge and never reaches memory. Non-exclusive accesses there, and exclusive accesses just past the window, proceed normally.
- R6: When the owner's hold line goes low, the reservation ends at the next edge, even if the line rises again before the store.
- R7: A second exclusive read by the owner moves the reservation to the new word. A store to the old word is then refused and a store to the new word succeeds.
- R8: In stall mode (default), an access by another source to the reserved word is not forwarded and gets no response while the reservation lives. Once the owner releases, the access is forwarded and acknowledged on the third edge after the release. Accesses by other sources to other words proceed unhindered.
- R9: In break mode, an access by another source to the reserved word is forwarded at once and clears the reservation, so the owner's following conditional store is refused.
- R10: A memory error on a forwarded access is returned as a one-cycle bus_err on the second edge, and opens no reservation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock, rising edge |
| rst_n | input | 1 | active-low synchronous reset |
| bus_cyc | input | 1 | bus cycle valid |
| bus_stb | input | 1 | request strobe |
| bus_we | input | 1 | write request when high |
| bus_addr | input | ADDR_W | byte address of the request |
| bus_src | input | SRC_W | source tag of the requester |
| lock_hold | input | 2**SRC_W | per-source exclusive hold level |
| bus_ack | output | 1 | transfer acknowledge to the requester |
| bus_err | output | 1 | error response to the requester |
| mem_stb | output | 1 | strobe towards memory |
| mem_ack_i | input | 1 | memory acknowledge |
| mem_err_i | input | 1 | memory error |

## Verification
The assertions assume the classic single-outstanding bus discipline: a requester keeps address, tag and write flag steady from the first sampled strobe until it sees its response, then drops the strobe. They also assume that memory answers only while mem_stb is high. The stimulus drives one request at a time on the falling edge and holds it until the response. The bench's memory answers combinationally from mem_stb, and its error window lies away from every address used for reservations. Two instances, one per conflict mode, receive identical inputs. Each has its own behavioural reference model, so abandoned requests in the instance that is not under test stay legal for it.

// File: rtl/excl_resv_pkg.sv
package excl_resv_pkg;

   typedef enum logic [1:0] {
      PH_IDLE = 2'd0,
      PH_MEM  = 2'd1,
      PH_RESP = 2'd2
   } phase_e;

   typedef struct packed {
      logic wait_req;
      logic refuse;
      logic set_on_ack;
      logic clr_now;
   } verdict_t;

endpackage

// File: rtl/excl_resv_region.sv
module excl_resv_region #(
   parameter int unsigned ADDR_W = 32,
   parameter logic [ADDR_W-1:0] BASE = 32'hF000_0000,
   parameter int unsigned BYTES = 64
) (
   input  logic [ADDR_W-1:0] addr_i,
   output logic              inside_o
);
   localparam logic [ADDR_W-1:0] SPAN_M1 = ADDR_W'(BYTES - 1);
   localparam logic [ADDR_W-1:0] MASK    = ~SPAN_M1;

   assign inside_o = (addr_i & MASK) == BASE;
endmodule

// File: rtl/excl_resv_store.sv
module excl_resv_store #(
   parameter int unsigned SRC_W   = 2,
   parameter int unsigned WORD_W  = 30,
   parameter int unsigned NUM_SRC = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               set_i,
   input  logic               clr_i,
   input  logic [WORD_W-1:0]  word_i,
   input  logic [SRC_W-1:0]   src_i,
   input  logic [NUM_SRC-1:0] lock_hold_i,
   output logic               vld_o,
   output logic [SRC_W-1:0]   owner_o,
   output logic [WORD_W-1:0]  word_o
);
   logic released;

   assign released = vld_o && !lock_hold_i[owner_o];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         vld_o   <= 1'b0;
         owner_o <= '0;
         word_o  <= '0;
      end else if (set_i) begin
         vld_o   <= 1'b1;
         owner_o <= src_i;
         word_o  <= word_i;
      end else if (clr_i || released) begin
         vld_o   <= 1'b0;
      end
   end
endmodule

// File: rtl/excl_resv_decide.sv
module excl_resv_decide
   import excl_resv_pkg::*;
#(
   parameter int unsigned SRC_W  = 2,
   parameter int unsigned WORD_W = 30,
   parameter bit STALL_ON_CONFLICT = 1'b1
) (
   input  logic              excl_i,
   input  logic              we_i,
   input  logic              inreg_i,
   input  logic [SRC_W-1:0]  src_i,
   input  logic [WORD_W-1:0] word_i,
   input  logic              rsv_vld_i,
   input  logic [SRC_W-1:0]  rsv_owner_i,
   input  logic [WORD_W-1:0] rsv_word_i,
   output verdict_t          verdict_o
);
   logic hit, conflict, own, own_hit;
   logic conf_wait, conf_break;

   assign hit      = rsv_vld_i && (word_i == rsv_word_i);
   assign own      = rsv_vld_i && (rsv_owner_i == src_i);
   assign conflict = hit && !own;
   assign own_hit  = hit && own;

   generate
      if (STALL_ON_CONFLICT) begin : g_stall
         assign conf_wait  = conflict;
         assign conf_break = 1'b0;
      end else begin : g_break
         assign conf_wait  = 1'b0;
         assign conf_break = conflict;
      end
   endgenerate

   always_comb begin
      verdict_o = '0;
      if (excl_i && inreg_i) begin
         verdict_o.refuse  = 1'b1;
         verdict_o.clr_now = own;
      end else if (conf_wait) begin
         verdict_o.wait_req = 1'b1;
      end else begin
         verdict_o.clr_now = conf_break;
         if (excl_i && we_i) begin
            verdict_o.refuse  = !own_hit;
            verdict_o.clr_now = conf_break | own;
         end else if (excl_i) begin
            verdict_o.set_on_ack = 1'b1;
         end
      end
   end
endmodule

// File: rtl/excl_resv_monitor.sv
module excl_resv_monitor
   import excl_resv_pkg::*;
#(
   parameter int unsigned ADDR_W = 32,
   parameter int unsigned SRC_W  = 2,
   parameter logic [ADDR_W-1:0] NOATOM_BASE = 32'hF000_0000,
   parameter int unsigned NOATOM_BYTES = 64,
   parameter bit STALL_ON_CONFLICT = 1'b1
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   bus_cyc,
   input  logic                   bus_stb,
   input  logic                   bus_we,
   input  logic [ADDR_W-1:0]      bus_addr,
   input  logic [SRC_W-1:0]       bus_src,
   input  logic [(1<<SRC_W)-1:0]  lock_hold,
   output logic                   bus_ack,
   output logic                   bus_err,
   output logic                   mem_stb,
   input  logic                   mem_ack_i,
   input  logic                   mem_err_i
);
   localparam int unsigned NUM_SRC = 1 << SRC_W;
   localparam int unsigned WORD_W  = ADDR_W - 2;

   generate
      if (ADDR_W < 8) begin : g_bad_addr
         $error("ADDR_W too small for word reservations");
      end
      if (NOATOM_BYTES < 4 || (NOATOM_BYTES & (NOATOM_BYTES - 1)) != 0) begin : g_bad_span
         $error("NOATOM_BYTES must be a power of two of at least 4");
      end
      if ((NOATOM_BASE & ADDR_W'(NOATOM_BYTES - 1)) != '0) begin : g_bad_base
         $error("NOATOM_BASE must be aligned to NOATOM_BYTES");
      end
   endgenerate

   phase_e             phase_q;
   logic               ack_q, err_q, pend_set_q;
   logic               req, excl, inreg;
   logic [WORD_W-1:0]  req_word;
   logic               rsv_vld;
   logic [SRC_W-1:0]   rsv_owner;
   logic [WORD_W-1:0]  rsv_word;
   verdict_t           verdict;
   logic               store_set, store_clr;

   assign req      = bus_cyc && bus_stb;
   assign excl     = lock_hold[bus_src];
   assign req_word = bus_addr[ADDR_W-1:2];

   excl_resv_region #(
      .ADDR_W (ADDR_W),
      .BASE   (NOATOM_BASE),
      .BYTES  (NOATOM_BYTES)
   ) u_region (
      .addr_i   (bus_addr),
      .inside_o (inreg)
   );

   excl_resv_decide #(
      .SRC_W             (SRC_W),
      .WORD_W            (WORD_W),
      .STALL_ON_CONFLICT (STALL_ON_CONFLICT)
   ) u_decide (
      .excl_i      (excl),
      .we_i        (bus_we),
      .inreg_i     (inreg),
      .src_i       (bus_src),
      .word_i      (req_word),
      .rsv_vld_i   (rsv_vld),
      .rsv_owner_i (rsv_owner),
      .rsv_word_i  (rsv_word),
      .verdict_o   (verdict)
   );

   assign store_set = (phase_q == PH_MEM) && req && mem_ack_i && pend_set_q;
   assign store_clr = (phase_q == PH_IDLE) && req && verdict.clr_now;

   excl_resv_store #(
      .SRC_W   (SRC_W),
      .WORD_W  (WORD_W),
      .NUM_SRC (NUM_SRC)
   ) u_store (
      .clk         (clk),
      .rst_n       (rst_n),
      .set_i       (store_set),
      .clr_i       (store_clr),
      .word_i      (req_word),
      .src_i       (bus_src),
      .lock_hold_i (lock_hold),
      .vld_o       (rsv_vld),
      .owner_o     (rsv_owner),
      .word_o      (rsv_word)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase_q    <= PH_IDLE;
         ack_q      <= 1'b0;
         err_q      <= 1'b0;
         pend_set_q <= 1'b0;
      end else begin
         ack_q <= 1'b0;
         err_q <= 1'b0;
         unique case (phase_q)
            PH_IDLE: begin
               if (req && !verdict.wait_req) begin
                  if (verdict.refuse) begin
                     err_q   <= 1'b1;
                     phase_q <= PH_RESP;
                  end else begin
                     pend_set_q <= verdict.set_on_ack;
                     phase_q    <= PH_MEM;
                  end
               end
            end
            PH_MEM: begin
               if (!req) begin
                  phase_q <= PH_IDLE;
               end else if (mem_ack_i) begin
                  ack_q   <= 1'b1;
                  phase_q <= PH_RESP;
               end else if (mem_err_i) begin
                  err_q   <= 1'b1;
                  phase_q <= PH_RESP;
               end
            end
            default: phase_q <= PH_IDLE;
         endcase
      end
   end

   assign bus_ack = ack_q;
   assign bus_err = err_q;
   assign mem_stb = (phase_q == PH_MEM) && req;

endmodule

// File: rtl/excl_resv_monitor_chk.sv
module excl_resv_monitor_chk #(
   parameter int unsigned ADDR_W = 32,
   parameter int unsigned SRC_W  = 2,
   parameter logic [ADDR_W-1:0] NOATOM_BASE = 32'hF000_0000,
   parameter int unsigned NOATOM_BYTES = 64,
   parameter bit STALL_ON_CONFLICT = 1'b1
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  bus_cyc,
   input logic                  bus_stb,
   input logic [ADDR_W-1:0]     bus_addr,
   input logic [SRC_W-1:0]      bus_src,
   input logic [(1<<SRC_W)-1:0] lock_hold,
   input logic                  bus_ack,
   input logic                  bus_err,
   input logic                  mem_stb,
   input logic                  mem_ack_i,
   input logic                  rsv_vld,
   input logic [SRC_W-1:0]      rsv_owner,
   input logic [ADDR_W-3:0]     rsv_word
);
   localparam logic [ADDR_W-1:0] WIN_MASK = ~(ADDR_W'(NOATOM_BYTES - 1));

   logic c_req, c_excl, c_inwin, c_conflict;

   assign c_req      = bus_cyc && bus_stb;
   assign c_excl     = c_req && lock_hold[bus_src];
   assign c_inwin    = (bus_addr & WIN_MASK) == NOATOM_BASE;
   assign c_conflict = c_req && rsv_vld && (bus_src != rsv_owner)
                       && (bus_addr[ADDR_W-1:2] == rsv_word);

   assert_ack_from_mem_R2: assert property (@(posedge clk) disable iff (!rst_n)
      bus_ack |-> $past(mem_stb && mem_ack_i));

   assert_err_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
      bus_err |=> !bus_err);

   assert_resp_exclusive_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_ack && bus_err));

   assert_window_no_mem_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mem_stb) |-> !$past(c_excl && c_inwin));

   assert_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (rsv_vld && !lock_hold[rsv_owner] && !mem_stb) |=> !rsv_vld);

   generate
      if (STALL_ON_CONFLICT) begin : g_stall_chk
         assert_conflict_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
            c_conflict |=> !mem_stb);
      end else begin : g_break_chk
         assert_conflict_breaks_R9: assert property (@(posedge clk) disable iff (!rst_n)
            c_conflict |=> !rsv_vld);
      end
   endgenerate
endmodule

bind excl_resv_monitor excl_resv_monitor_chk #(
   .ADDR_W            (ADDR_W),
   .SRC_W             (SRC_W),
   .NOATOM_BASE       (NOATOM_BASE),
   .NOATOM_BYTES      (NOATOM_BYTES),
   .STALL_ON_CONFLICT (STALL_ON_CONFLICT)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_cyc   (bus_cyc),
   .bus_stb   (bus_stb),
   .bus_addr  (bus_addr),
   .bus_src   (bus_src),
   .lock_hold (lock_hold),
   .bus_ack   (bus_ack),
   .bus_err   (bus_err),
   .mem_stb   (mem_stb),
   .mem_ack_i (mem_ack_i),
   .rsv_vld   (rsv_vld),
   .rsv_owner (rsv_owner),
   .rsv_word  (rsv_word)
);

// File: tb/excl_resv_monitor_test.sv
`timescale 1ns/1ps
module excl_resv_monitor_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cyc = 1'b0, stb = 1'b0, we = 1'b0;
   logic [31:0] addr = '0;
   logic [1:0]  src = '0;
   logic [3:0]  lockh = '0;
   logic        ack_s, err_s, mstb_s, mack_s, merr_s;
   logic        ack_b, err_b, mstb_b, mack_b, merr_b;
   bit          sel_brk = 1'b0;
   int          n_chk = 0, n_err = 0;

   always #2 clk = ~clk;

   // memory: answers at once; addresses 0xE....... give an error
   assign mack_s = mstb_s && (addr[31:28] != 4'hE);
   assign merr_s = mstb_s && (addr[31:28] == 4'hE);
   assign mack_b = mstb_b && (addr[31:28] != 4'hE);
   assign merr_b = mstb_b && (addr[31:28] == 4'hE);

   excl_resv_monitor #(.STALL_ON_CONFLICT(1'b1)) uut (
      .clk(clk), .rst_n(rst_n), .bus_cyc(cyc), .bus_stb(stb), .bus_we(we),
      .bus_addr(addr), .bus_src(src), .lock_hold(lockh),
      .bus_ack(ack_s), .bus_err(err_s), .mem_stb(mstb_s),
      .mem_ack_i(mack_s), .mem_err_i(merr_s));

   excl_resv_monitor #(.STALL_ON_CONFLICT(1'b0)) uut_brk (
      .clk(clk), .rst_n(rst_n), .bus_cyc(cyc), .bus_stb(stb), .bus_we(we),
      .bus_addr(addr), .bus_src(src), .lock_hold(lockh),
      .bus_ack(ack_b), .bus_err(err_b), .mem_stb(mstb_b),
      .mem_ack_i(mack_b), .mem_err_i(merr_b));

   task automatic check(input bit ok, input string rq, input string what,
                        input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, exp);
      end
   endtask

   // behavioural reference: index 0 = stall instance, 1 = break instance
   int          m_ph[2];
   bit          m_rv[2], m_ack[2], m_err[2], m_pset[2];
   int          m_own[2];
   logic [29:0] m_word[2];

   always @(posedge clk) begin
      for (int m = 0; m < 2; m++) begin
         bit r, ex, win, hit, conf, own, clr, setn;
         r = cyc && stb;
         ex = lockh[src];
         win = (addr & 32'hFFFF_FFC0) == 32'hF000_0000;
         clr = 1'b0; setn = 1'b0;
         if (!rst_n) begin
            m_ph[m] = 0; m_rv[m] = 0; m_ack[m] = 0; m_err[m] = 0; m_pset[m] = 0;
         end else begin
            m_ack[m] = 0; m_err[m] = 0;
            if (m_ph[m] == 0) begin
               if (r) begin
                  hit  = m_rv[m] && (addr[31:2] == m_word[m]);
                  own  = m_rv[m] && (m_own[m] == int'(src));
                  conf = hit && !own;
                  if (ex && win) begin
                     m_err[m] = 1; m_ph[m] = 2; clr = own;
                  end else if (!(conf && m == 0)) begin
                     clr = conf;
                     if (ex && we) begin
                        clr = clr || own;
                        if (hit && own) begin m_ph[m] = 1; m_pset[m] = 0; end
                        else begin m_err[m] = 1; m_ph[m] = 2; end
                     end else begin
                        m_ph[m] = 1; m_pset[m] = ex;
                     end
                  end
               end
            end else if (m_ph[m] == 1) begin
               if (!r) m_ph[m] = 0;
               else if (addr[31:28] == 4'hE) begin m_err[m] = 1; m_ph[m] = 2; end
               else begin m_ack[m] = 1; m_ph[m] = 2; setn = m_pset[m]; end
            end else begin
               m_ph[m] = 0;
            end
            if (setn) begin
               m_rv[m] = 1; m_own[m] = int'(src); m_word[m] = addr[31:2];
            end else if (clr || (m_rv[m] && !lockh[m_own[m]])) begin
               m_rv[m] = 0;
            end
         end
      end
   end

   // every-cycle comparison against the reference, away from both edges
   always @(negedge clk) begin
      #1;
      if (rst_n) begin
         for (int m = 0; m < 2; m++) begin
            bit a, e, s, ms;
            a = (m == 0) ? ack_s : ack_b;
            e = (m == 0) ? err_s : err_b;
            s = (m == 0) ? mstb_s : mstb_b;
            ms = (m_ph[m] == 1) && cyc && stb;
            check(a == m_ack[m], "R2", $sformatf("ack vs model inst%0d", m), a, m_ack[m]);
            check(e == m_err[m], "R4", $sformatf("err vs model inst%0d", m), e, m_err[m]);
            check(s == ms, "R8", $sformatf("mem_stb vs model inst%0d", m), s, ms);
         end
      end
   end

   task automatic access(input bit w, input logic [31:0] a, input int s,
                         input bit exp_err, input int exp_lat, input bit exp_mem,
                         input string rq);
      bit got_a = 0, got_e = 0, seen = 0;
      int lat = 0;
      @(negedge clk);
      cyc = 1; stb = 1; we = w; addr = a; src = 2'(s);
      while (!got_a && !got_e && lat < 30) begin
         @(negedge clk);
         lat++;
         if (sel_brk ? mstb_b : mstb_s) seen = 1;
         got_a = sel_brk ? ack_b : ack_s;
         got_e = sel_brk ? err_b : err_s;
      end
      cyc = 0; stb = 0;
      check(got_e == exp_err && got_a == !exp_err, rq,
            $sformatf("response kind at %h (1=err)", a), int'(got_e), int'(exp_err));
      check(lat == exp_lat, rq, $sformatf("latency at %h", a), lat, exp_lat);
      check(seen == exp_mem, rq, $sformatf("memory strobe at %h", a), int'(seen), int'(exp_mem));
   endtask

   task automatic do_reset();
      @(negedge clk); rst_n = 0; lockh = '0; cyc = 0; stb = 0;
      repeat (3) @(negedge clk);
      rst_n = 1;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      n_err++;
      $display("FAIL R1 watchdog expired");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      repeat (2) @(negedge clk);
      // R1: quiet while in reset
      check(!ack_s && !err_s && !mstb_s && !ack_b && !err_b && !mstb_b, "R1",
            "outputs in reset", int'(ack_s | err_s | mstb_s), 0);
      rst_n = 1;
      // R1: no reservation after reset
      lockh[0] = 1;
      access(1, 32'h100, 0, 1, 1, 0, "R1");
      // R2 / R3: open, store with bits 1:0 differing, repeat refused
      access(0, 32'h100, 0, 0, 2, 1, "R2");
      access(1, 32'h102, 0, 0, 2, 1, "R3");
      access(1, 32'h100, 0, 1, 1, 0, "R3");
      // R4: wrong word, then cleared by the failure
      lockh[1] = 1;
      access(0, 32'h200, 1, 0, 2, 1, "R4");
      access(1, 32'h204, 1, 1, 1, 0, "R4");
      access(1, 32'h200, 1, 1, 1, 0, "R4");
      // R4: store by a source that is not the owner
      access(0, 32'h210, 1, 0, 2, 1, "R4");
      lockh[2] = 1;
      access(1, 32'h220, 2, 1, 1, 0, "R4");
      access(1, 32'h210, 1, 0, 2, 1, "R4");
      // R5: refused window and its neighbours
      access(0, 32'hF000_0020, 2, 1, 1, 0, "R5");
      access(1, 32'hF000_003C, 2, 1, 1, 0, "R5");
      lockh[2] = 0;
      access(0, 32'hF000_0010, 2, 0, 2, 1, "R5");
      lockh[2] = 1;
      access(0, 32'hF000_0040, 2, 0, 2, 1, "R5");
      lockh[2] = 0;
      // R6: a brief drop of the hold line ends the reservation
      access(0, 32'h300, 0, 0, 2, 1, "R6");
      @(negedge clk); lockh[0] = 0;
      @(negedge clk); lockh[0] = 1;
      access(1, 32'h300, 0, 1, 1, 0, "R6");
      // R7: second exclusive read moves the reservation
      access(0, 32'h400, 0, 0, 2, 1, "R7");
      access(0, 32'h500, 0, 0, 2, 1, "R7");
      access(1, 32'h400, 0, 1, 1, 0, "R7");
      access(0, 32'h400, 0, 0, 2, 1, "R7");
      access(0, 32'h500, 0, 0, 2, 1, "R7");
      access(1, 32'h500, 0, 0, 2, 1, "R7");
      // R10: memory error on an exclusive read
      lockh[3] = 1;
      access(0, 32'hE000_0000, 3, 1, 2, 1, "R10");
      lockh[3] = 0; lockh[1] = 0;
      // R8: stall mode
      access(0, 32'h600, 0, 0, 2, 1, "R8");
      access(1, 32'h604, 1, 0, 2, 1, "R8");
      begin
         bit quiet = 1;
         int lat = 0;
         bit got = 0;
         @(negedge clk);
         cyc = 1; stb = 1; we = 1; addr = 32'h600; src = 2'd1;
         repeat (6) begin
            @(negedge clk);
            if (ack_s || err_s || mstb_s) quiet = 0;
         end
         check(quiet, "R8", "stalled access stays silent", int'(!quiet), 0);
         lockh[0] = 0;
         while (!got && lat < 30) begin
            @(negedge clk);
            lat++;
            got = ack_s;
         end
         cyc = 0; stb = 0;
         check(got && lat == 3, "R8", "ack latency after release", lat, 3);
      end
      // R9: break mode
      do_reset();
      sel_brk = 1;
      lockh[0] = 1;
      access(0, 32'h700, 0, 0, 2, 1, "R9");
      access(1, 32'h700, 1, 0, 2, 1, "R9");
      access(1, 32'h700, 0, 1, 1, 0, "R9");
      repeat (3) @(negedge clk);
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule